// File: doc/BRIEF.md
# Exception Entry Status Encoder

This block turns an exception request into the complete processor state update needed to enter a handler. A request carries a 4-bit exception code and a set of cause flags; together with the current machine-state word and the current instruction address, the block computes the handler vector, the saved status word, the saved return address, the data-fault status word and the machine-state word that applies inside the handler. All results appear together, registered, one clock after the request is accepted. A one-cycle flush pulse marks each accepted entry, so that a neighbouring translation cache can drop its contents.

External and decrementer interrupts are maskable. When the enable bit in the machine-state word is 0 they are not taken; a pending flag per source remembers them. They are taken later, on a cycle with no new request, once the enable bit reads 1. A machine check that arrives while machine checks are disabled stops the block until reset.

Machine-state bit positions used throughout: LE=0, RI=1, DR=4, IR=5, IP=6, FE1=8, BE=9, SE=10, FE0=11, ME=12, FP=13, PR=14, EE=15, ILE=16, POW=18. Exception codes: 1 reset, 2 machine check, 3 data storage, 4 instruction storage, 5 external, 6 alignment, 7 program, 8 FP unavailable, 9 decrementer, 12 system call, 13 trace, 14 FP assist. Cause flag bits: 0 no translation, 1 protection, 2 unsupported, 3 direct-store, 4 store, 5 breakpoint match, 6 external-control, 7 no-execute, 8 guarded, 9 FP enabled, 10 illegal, 11 privileged, 12 trap.

Top module: `exc_entry_encoder`

## Requirements
- R1: After a synchronous active-low reset, every output is 0.
- R2: An accepted request gives `entry_flush`=1 for exactly the following cycle, and `vector` = code shifted left by 8; a reset (code 1) with IP=1 gives `vector` = 0xFFF00100 instead.
- R3: `msr_next` is `msr_in` with POW, EE, PR, FP, FE0, FE1, SE, BE, IR, DR and RI cleared and LE replaced by ILE; all other bits are kept.
- R4: `save_pc` is `nip_in`-4 for codes 6, 7 and 8, is left unchanged for a machine check, and is `nip_in` for every other code.
- R5: For codes 3, 4 and 7, `save_status` is `msr_in` with bits 31:16 cleared and the cause bits of R6/R7 added; for all other codes it is `msr_in` unchanged.
- R6: Instruction storage (code 4) adds bit 30 for no translation, else bit 28 if no-execute, guarded or direct-store is set, else bit 27.
- R7: Program (code 7) adds bit 16 always, plus the first of: bit 20 for FP enabled, bit 19 for illegal, bit 18 for privileged, bit 17 for trap.
- R8: Data storage (code 3) sets `fault_status` from zero: bit 30 for no translation, else bit 27 for protection, else bit 31 for unsupported with bit 26 added when direct-store; independently bit 25 for store, bit 22 for breakpoint match, bit 20 for external-control.
- R9: `fault_status` keeps its value across entries of any code other than 3.
- R10: A code 5 or 9 request with EE=0 sets `pend_ext` or `pend_dec` and is not taken; a pending source is taken on a cycle with `req_valid`=0 and EE=1, external before decrementer, and its flag clears; a new request always wins over a pending one.
- R11: A machine check with ME=1 is taken with ME cleared in `msr_next`; with ME=0 it sets `halted`, after which no request is taken and all outputs hold until reset.
- R12: Requests with codes 0, 10, 11 and 15 are ignored: no flush pulse and no output change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Exception request present this cycle |
| req_kind | input | 4 | Exception code |
| req_cause | input | 13 | Cause flags |
| msr_in | input | 32 | Current machine-state word |
| nip_in | input | 32 | Address of the next instruction |
| entry_flush | output | 1 | One-cycle pulse per accepted entry |
| vector | output | 32 | Handler address |
| save_status | output | 32 | Saved status word |
| save_pc | output | 32 | Saved return address |
| fault_status | output | 32 | Data-fault status word |
| msr_next | output | 32 | Machine-state word for the handler |
| pend_ext | output | 1 | External interrupt waiting |
| pend_dec | output | 1 | Decrementer interrupt waiting |
| halted | output | 1 | Fatal machine check seen |

## Verification
The hardest situation to reach is both maskable sources pending at once while the enable bit flips, since it needs two deferred requests, then idle cycles with the enable bit raised, and a competing new request to show that fresh requests win. The stimulus builds this in sequence: external and decrementer requests under EE=0, then a system call with EE=1 while a flag is pending, then idle cycles that drain the flags in order. A random phase with periodic resets then compares every output each cycle against a behavioural model, which also reaches the fatal machine-check stop from many machine-state values.

// File: rtl/exc_entry_pkg.sv
// Package: shared codes, cause-flag positions and machine-state bit positions
// for the exception entry encoder. Assumes a 32-bit machine-state word.
package exc_entry_pkg;

    typedef enum logic [3:0] {
        EK_NONE  = 4'd0,
        EK_RESET = 4'd1,
        EK_MCHK  = 4'd2,
        EK_DSTOR = 4'd3,
        EK_ISTOR = 4'd4,
        EK_EXT   = 4'd5,
        EK_ALIGN = 4'd6,
        EK_PROG  = 4'd7,
        EK_NOFPU = 4'd8,
        EK_DECR  = 4'd9,
        EK_SYSC  = 4'd12,
        EK_TRACE = 4'd13,
        EK_FPAST = 4'd14
    } exc_kind_e;

    localparam int KIND_W  = 4;
    localparam int CAUSE_W = 13;

    // Cause flag positions
    localparam int CF_NOXLATE = 0;
    localparam int CF_PROT    = 1;
    localparam int CF_UNSUP   = 2;
    localparam int CF_DIRECT  = 3;
    localparam int CF_STORE   = 4;
    localparam int CF_BRKPT   = 5;
    localparam int CF_EXTCTL  = 6;
    localparam int CF_NOEXEC  = 7;
    localparam int CF_GUARD   = 8;
    localparam int CF_FPEN    = 9;
    localparam int CF_ILLEGAL = 10;
    localparam int CF_PRIV    = 11;
    localparam int CF_TRAP    = 12;

    // Machine-state bit positions
    localparam int MB_LE  = 0;
    localparam int MB_RI  = 1;
    localparam int MB_DR  = 4;
    localparam int MB_IR  = 5;
    localparam int MB_IP  = 6;
    localparam int MB_FE1 = 8;
    localparam int MB_BE  = 9;
    localparam int MB_SE  = 10;
    localparam int MB_FE0 = 11;
    localparam int MB_ME  = 12;
    localparam int MB_FP  = 13;
    localparam int MB_PR  = 14;
    localparam int MB_EE  = 15;
    localparam int MB_ILE = 16;
    localparam int MB_POW = 18;

    // Status bit positions in saved status / fault status words
    localparam int SB_UNSUP   = 31;
    localparam int SB_NOXLATE = 30;
    localparam int SB_NOEXEC  = 28;
    localparam int SB_PROT    = 27;
    localparam int SB_DIRECT  = 26;
    localparam int SB_STORE   = 25;
    localparam int SB_BRKPT   = 22;
    localparam int SB_EXTCTL  = 20;
    localparam int SB_PFP     = 20;
    localparam int SB_PILL    = 19;
    localparam int SB_PPRIV   = 18;
    localparam int SB_PTRAP   = 17;
    localparam int SB_PANY    = 16;

    // True for every code the block acts on
    function automatic logic kind_known(input logic [KIND_W-1:0] k);
        case (k)
            EK_RESET, EK_MCHK, EK_DSTOR, EK_ISTOR, EK_EXT, EK_ALIGN,
            EK_PROG, EK_NOFPU, EK_DECR, EK_SYSC, EK_TRACE, EK_FPAST:
                return 1'b1;
            default:
                return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/exc_cause_encoder.sv
// Module: combinational encoder of fault causes into the saved status word
// and the data-fault status word. Assumes XLEN >= 32 so that every status
// bit position exists; the upper half of the state is cleared for storage
// and program faults.
module exc_cause_encoder
    import exc_entry_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [KIND_W-1:0]  kind,
    input  logic [CAUSE_W-1:0] cause,
    input  logic [XLEN-1:0]    msr,
    output logic [XLEN-1:0]    save_status,
    output logic [XLEN-1:0]    fault_status,
    output logic               fault_wr
);
    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] LOW_MASK = {{(XLEN-HALF){1'b0}}, {HALF{1'b1}}};

    logic [XLEN-1:0] isi_bits;
    logic [XLEN-1:0] prog_bits;
    logic [XLEN-1:0] dsi_bits;

    // Instruction storage cause: first matching class wins
    always_comb begin
        isi_bits = '0;
        if (cause[CF_NOXLATE])
            isi_bits[SB_NOXLATE] = 1'b1;
        else if (cause[CF_NOEXEC] || cause[CF_GUARD] || cause[CF_DIRECT])
            isi_bits[SB_NOEXEC] = 1'b1;
        else
            isi_bits[SB_PROT] = 1'b1;
    end

    // Program cause: one class bit by priority plus the common marker
    always_comb begin
        prog_bits = '0;
        prog_bits[SB_PANY] = 1'b1;
        if (cause[CF_FPEN])
            prog_bits[SB_PFP] = 1'b1;
        else if (cause[CF_ILLEGAL])
            prog_bits[SB_PILL] = 1'b1;
        else if (cause[CF_PRIV])
            prog_bits[SB_PPRIV] = 1'b1;
        else if (cause[CF_TRAP])
            prog_bits[SB_PTRAP] = 1'b1;
    end

    // Data storage cause: one primary class plus independent qualifiers
    always_comb begin
        dsi_bits = '0;
        if (cause[CF_NOXLATE]) begin
            dsi_bits[SB_NOXLATE] = 1'b1;
        end else if (cause[CF_PROT]) begin
            dsi_bits[SB_PROT] = 1'b1;
        end else if (cause[CF_UNSUP]) begin
            dsi_bits[SB_UNSUP]  = 1'b1;
            dsi_bits[SB_DIRECT] = cause[CF_DIRECT];
        end
        dsi_bits[SB_STORE]  = cause[CF_STORE];
        dsi_bits[SB_BRKPT]  = cause[CF_BRKPT];
        dsi_bits[SB_EXTCTL] = cause[CF_EXTCTL];
    end

    // Select the saved status form by exception code
    always_comb begin
        fault_status = dsi_bits;
        fault_wr     = 1'b0;
        case (kind)
            EK_DSTOR: begin
                save_status = msr & LOW_MASK;
                fault_wr    = 1'b1;
            end
            EK_ISTOR: save_status = (msr & LOW_MASK) | isi_bits;
            EK_PROG:  save_status = (msr & LOW_MASK) | prog_bits;
            default:  save_status = msr;
        endcase
    end

endmodule

// File: rtl/exc_state_builder.sv
// Module: computes the handler's machine-state word and the handler vector.
// Assumes the vector is the code shifted by VEC_SHIFT, relocated into the
// high base when a reset arrives with the prefix bit set.
module exc_state_builder
    import exc_entry_pkg::*;
#(
    parameter int              XLEN      = 32,
    parameter int              VEC_SHIFT = 8,
    parameter logic [XLEN-1:0] HIGH_BASE = 32'hFFF0_0000
) (
    input  logic [KIND_W-1:0] kind,
    input  logic [XLEN-1:0]   msr,
    output logic [XLEN-1:0]   new_msr,
    output logic [XLEN-1:0]   vector
);
    localparam int N_CLR = 11;
    localparam int CLR_POS [N_CLR] = '{MB_POW, MB_EE, MB_PR, MB_FP, MB_FE0,
                                       MB_FE1, MB_SE, MB_BE, MB_IR, MB_DR,
                                       MB_RI};

    logic [XLEN-1:0] clr_mask;
    logic [XLEN-1:0] base_vec;

    // One mask bit per cleared state field
    generate
        for (genvar g = 0; g < XLEN; g++) begin : g_mask
            logic hit;
            always_comb begin
                hit = 1'b0;
                for (int j = 0; j < N_CLR; j++)
                    if (CLR_POS[j] == g) hit = 1'b1;
            end
            assign clr_mask[g] = hit;
        end
    endgenerate

    // Handler state: clear listed fields, LE from ILE, ME off for machine check
    always_comb begin
        new_msr        = msr & ~clr_mask;
        new_msr[MB_LE] = msr[MB_ILE];
        if (kind == EK_MCHK)
            new_msr[MB_ME] = 1'b0;
    end

    // Handler vector with optional high relocation for reset
    always_comb begin
        base_vec = '0;
        base_vec[VEC_SHIFT +: KIND_W] = kind;
        if (kind == EK_RESET && msr[MB_IP])
            vector = HIGH_BASE | base_vec;
        else
            vector = base_vec;
    end

endmodule

// File: rtl/exc_return_select.sv
// Module: picks the saved return address. Assumes fixed-size instructions
// of INSN_BYTES; the machine check leaves the previous value in place.
module exc_return_select
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [KIND_W-1:0] kind,
    input  logic [XLEN-1:0]   nip,
    output logic [XLEN-1:0]   ret_addr,
    output logic              ret_keep
);
    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    // Current instruction for synchronous faults, next one otherwise
    always_comb begin
        ret_keep = 1'b0;
        ret_addr = nip;
        case (kind)
            EK_ALIGN, EK_PROG, EK_NOFPU: ret_addr = nip - STEP;
            EK_MCHK:                     ret_keep = 1'b1;
            default:                     ret_addr = nip;
        endcase
    end

endmodule

// File: rtl/exc_defer_tracker.sv
// Module: holds one pending flag per maskable source and chooses the event
// to take this cycle. A new request beats any pending source; pending
// sources are taken in index order once enabled. Assumes frozen holds all
// flags (fatal stop).
module exc_defer_tracker
    import exc_entry_pkg::*;
#(
    parameter int N_SRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frozen,
    input  logic              req_valid,
    input  logic [KIND_W-1:0] req_kind,
    input  logic              enable,
    output logic              evt_valid,
    output logic [KIND_W-1:0] evt_kind,
    output logic [N_SRC-1:0]  pending
);
    localparam logic [KIND_W-1:0] SRC_KIND [2] = '{EK_EXT, EK_DECR};

    logic req_known;
    logic req_masked;

    // Classify the incoming request
    always_comb begin
        req_known  = kind_known(req_kind);
        req_masked = 1'b0;
        for (int i = 0; i < N_SRC; i++)
            if (req_kind == SRC_KIND[i]) req_masked = 1'b1;
    end

    // Choose between the new request and the first pending source
    always_comb begin
        evt_valid = 1'b0;
        evt_kind  = EK_NONE;
        if (req_valid) begin
            if (req_known && (!req_masked || enable)) begin
                evt_valid = 1'b1;
                evt_kind  = req_kind;
            end
        end else if (enable) begin
            for (int i = N_SRC - 1; i >= 0; i--) begin
                if (pending[i]) begin
                    evt_valid = 1'b1;
                    evt_kind  = SRC_KIND[i];
                end
            end
        end
    end

    generate
        for (genvar s = 0; s < N_SRC; s++) begin : g_src
            // Set on a masked request, clear when this source is taken
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pending[s] <= 1'b0;
                else if (!frozen) begin
                    if (req_valid && req_kind == SRC_KIND[s] && !enable)
                        pending[s] <= 1'b1;
                    else if (evt_valid && evt_kind == SRC_KIND[s])
                        pending[s] <= 1'b0;
                end
            end
        end
    endgenerate

endmodule

// File: rtl/exc_entry_encoder.sv
// Module: top of the exception entry encoder. Registers the handler vector,
// saved status, return address, fault status and handler state one cycle
// after an accepted event, pulses entry_flush, and stops on a machine check
// that arrives with machine checks disabled. Synchronous active-low reset.
module exc_entry_encoder
    import exc_entry_pkg::*;
#(
    parameter int XLEN       = 32,
    parameter int VEC_SHIFT  = 8,
    parameter int INSN_BYTES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [KIND_W-1:0]  req_kind,
    input  logic [CAUSE_W-1:0] req_cause,
    input  logic [XLEN-1:0]    msr_in,
    input  logic [XLEN-1:0]    nip_in,
    output logic               entry_flush,
    output logic [XLEN-1:0]    vector,
    output logic [XLEN-1:0]    save_status,
    output logic [XLEN-1:0]    save_pc,
    output logic [XLEN-1:0]    fault_status,
    output logic [XLEN-1:0]    msr_next,
    output logic               pend_ext,
    output logic               pend_dec,
    output logic               halted
);
    localparam int N_SRC = 2;

    logic              evt_valid;
    logic [KIND_W-1:0] evt_kind;
    logic [N_SRC-1:0]  pending;
    logic              fatal_hit;
    logic              go;
    logic [XLEN-1:0]   c_save;
    logic [XLEN-1:0]   c_fault;
    logic              c_fault_wr;
    logic [XLEN-1:0]   c_msr;
    logic [XLEN-1:0]   c_vec;
    logic [XLEN-1:0]   c_ret;
    logic              c_ret_keep;

    exc_defer_tracker #(.N_SRC(N_SRC)) u_defer (
        .clk       (clk),
        .rst_n     (rst_n),
        .frozen    (halted),
        .req_valid (req_valid),
        .req_kind  (req_kind),
        .enable    (msr_in[MB_EE]),
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .pending   (pending)
    );

    exc_cause_encoder #(.XLEN(XLEN)) u_cause (
        .kind         (evt_kind),
        .cause        (req_cause),
        .msr          (msr_in),
        .save_status  (c_save),
        .fault_status (c_fault),
        .fault_wr     (c_fault_wr)
    );

    exc_state_builder #(.XLEN(XLEN), .VEC_SHIFT(VEC_SHIFT)) u_state (
        .kind    (evt_kind),
        .msr     (msr_in),
        .new_msr (c_msr),
        .vector  (c_vec)
    );

    exc_return_select #(.XLEN(XLEN), .INSN_BYTES(INSN_BYTES)) u_ret (
        .kind     (evt_kind),
        .nip      (nip_in),
        .ret_addr (c_ret),
        .ret_keep (c_ret_keep)
    );

    // Split the chosen event into a fatal stop or a normal entry
    always_comb begin
        fatal_hit = evt_valid && evt_kind == EK_MCHK && !msr_in[MB_ME];
        go        = evt_valid && !fatal_hit;
    end

    assign pend_ext = pending[0];
    assign pend_dec = pending[1];

    // Register entry results; everything holds once halted
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            entry_flush  <= 1'b0;
            vector       <= '0;
            save_status  <= '0;
            save_pc      <= '0;
            fault_status <= '0;
            msr_next     <= '0;
            halted       <= 1'b0;
        end else begin
            entry_flush <= 1'b0;
            if (!halted) begin
                if (fatal_hit) begin
                    halted <= 1'b1;
                end else if (go) begin
                    entry_flush <= 1'b1;
                    vector      <= c_vec;
                    save_status <= c_save;
                    msr_next    <= c_msr;
                    if (!c_ret_keep)
                        save_pc <= c_ret;
                    if (c_fault_wr)
                        fault_status <= c_fault;
                end
            end
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
// Checker: temporal properties of the exception entry encoder, bound to
// the top module.
module exc_entry_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic [3:0]  req_kind,
    input logic [31:0] msr_in,
    input logic        entry_flush,
    input logic [31:0] vector,
    input logic [31:0] fault_status,
    input logic [31:0] msr_next,
    input logic        pend_ext,
    input logic        halted
);
    localparam logic [31:0] CLEARED = 32'h0004_EF32;
    localparam logic [31:0] FS_OK   = 32'hCE50_0000;

    a_r2_vector_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        entry_flush |-> (vector[7:0] == 8'h00));

    a_r3_entry_fields_clear: assert property (@(posedge clk) disable iff (!rst_n)
        entry_flush |-> ((msr_next & CLEARED) == 32'h0));

    a_r8_fault_bits_legal: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_status & ~FS_OK) == 32'h0);

    a_r10_masked_external_deferred: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 4'd5 && !msr_in[15] && !halted) |=> (pend_ext && !entry_flush));

    a_r11_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    a_r11_no_entry_halted: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> !entry_flush);

    a_r11_mchk_clears_me: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_flush && vector == 32'h200) |-> !msr_next[12]);

    a_r12_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_kind == 4'd0 || req_kind == 4'd10 || req_kind == 4'd11 ||
                       req_kind == 4'd15)) |=> !entry_flush);

endmodule

bind exc_entry_encoder exc_entry_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_kind     (req_kind),
    .msr_in       (msr_in),
    .entry_flush  (entry_flush),
    .vector       (vector),
    .fault_status (fault_status),
    .msr_next     (msr_next),
    .pend_ext     (pend_ext),
    .halted       (halted)
);

// File: tb/tb_exc_entry_encoder.sv
`timescale 1ns/1ps
module tb_exc_entry_encoder;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [3:0]  req_kind = 4'd0;
    logic [12:0] req_cause = 13'd0;
    logic [31:0] msr_in = 32'd0;
    logic [31:0] nip_in = 32'd0;
    logic        entry_flush;
    logic [31:0] vector, save_status, save_pc, fault_status, msr_next;
    logic        pend_ext, pend_dec, halted;

    int n_chk = 0;
    int n_err = 0;
    bit cmp_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    exc_entry_encoder dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
        .req_cause(req_cause), .msr_in(msr_in), .nip_in(nip_in),
        .entry_flush(entry_flush), .vector(vector), .save_status(save_status),
        .save_pc(save_pc), .fault_status(fault_status), .msr_next(msr_next),
        .pend_ext(pend_ext), .pend_dec(pend_dec), .halted(halted)
    );

    // ---------------- reference model (behavioural) ----------------
    logic        m_flush, m_pe, m_pd, m_halt;
    logic [31:0] m_vec, m_save, m_ret, m_fault, m_msr;

    function automatic bit legal_code(input int k);
        return (k >= 1 && k <= 9) || (k >= 12 && k <= 14);
    endfunction

    function automatic logic [31:0] exp_msr(input int k, input logic [31:0] m);
        logic [31:0] r;
        r = m;
        foreach (r[i]) if (i inside {18, 15, 14, 13, 11, 8, 10, 9, 5, 4, 1}) r[i] = 1'b0;
        r[0] = m[16];
        if (k == 2) r[12] = 1'b0;
        return r;
    endfunction

    function automatic logic [31:0] exp_save(input int k, input logic [12:0] c, input logic [31:0] m);
        logic [31:0] lo;
        lo = m & 32'h0000_FFFF;
        if (k == 3) return lo;
        if (k == 4) begin
            if (c[0]) return lo | 32'h4000_0000;
            if (c[7] | c[8] | c[3]) return lo | 32'h1000_0000;
            return lo | 32'h0800_0000;
        end
        if (k == 7) begin
            lo = lo | 32'h0001_0000;
            if (c[9]) return lo | 32'h0010_0000;
            if (c[10]) return lo | 32'h0008_0000;
            if (c[11]) return lo | 32'h0004_0000;
            if (c[12]) return lo | 32'h0002_0000;
            return lo;
        end
        return m;
    endfunction

    function automatic logic [31:0] exp_fault(input logic [12:0] c);
        logic [31:0] f;
        f = 0;
        if (c[0]) f = 32'h4000_0000;
        else if (c[1]) f = 32'h0800_0000;
        else if (c[2]) f = c[3] ? 32'h8400_0000 : 32'h8000_0000;
        if (c[4]) f = f | 32'h0200_0000;
        if (c[5]) f = f | 32'h0040_0000;
        if (c[6]) f = f | 32'h0010_0000;
        return f;
    endfunction

    always @(posedge clk) begin
        int k;
        if (!rst_n) begin
            m_flush = 0; m_pe = 0; m_pd = 0; m_halt = 0;
            m_vec = 0; m_save = 0; m_ret = 0; m_fault = 0; m_msr = 0;
        end else begin
            m_flush = 0;
            if (!m_halt) begin
                k = -1;
                if (req_valid) begin
                    if (legal_code(int'(req_kind))) begin
                        if ((req_kind == 5 || req_kind == 9) && !msr_in[15]) begin
                            if (req_kind == 5) m_pe = 1; else m_pd = 1;
                        end else k = int'(req_kind);
                    end
                end else if (msr_in[15] && m_pe) k = 5;
                else if (msr_in[15] && m_pd) k = 9;
                if (k == 2 && !msr_in[12]) m_halt = 1;
                else if (k >= 0) begin
                    m_flush = 1;
                    m_vec = (k == 1 && msr_in[6]) ? 32'hFFF0_0100 : 32'(k * 256);
                    m_save = exp_save(k, req_cause, msr_in);
                    m_msr = exp_msr(k, msr_in);
                    if (k == 6 || k == 7 || k == 8) m_ret = nip_in - 4;
                    else if (k != 2) m_ret = nip_in;
                    if (k == 3) m_fault = exp_fault(req_cause);
                    if (k == 5) m_pe = 0;
                    if (k == 9) m_pd = 0;
                end
            end
        end
    end

    // ---------------- checking helpers ----------------
    task automatic chk32(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Compare every output against the model away from the active edge
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            chk32("R2 flush",    {31'd0, entry_flush}, {31'd0, m_flush});
            chk32("R2 vector",   vector, m_vec);
            chk32("R5 save",     save_status, m_save);
            chk32("R4 ret",      save_pc, m_ret);
            chk32("R8 fault",    fault_status, m_fault);
            chk32("R3 msr",      msr_next, m_msr);
            chk32("R10 pend",    {30'd0, pend_dec, pend_ext}, {30'd0, m_pd, m_pe});
            chk32("R11 halt",    {31'd0, halted}, {31'd0, m_halt});
        end
    end

    // Drive one request for one edge; outputs are readable on return
    task automatic step(input logic [3:0] k, input logic [12:0] c,
                        input logic [31:0] m, input logic [31:0] n);
        @(negedge clk); #1;
        req_valid = 1'b1; req_kind = k; req_cause = c; msr_in = m; nip_in = n;
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic idle_edge();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 1'b0; req_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    localparam logic [31:0] MSR_A = 32'h0031_F03A;
    localparam logic [31:0] MSR_B = 32'h0031_703A; // EE=0
    localparam logic [31:0] MSR_C = 32'h0031_E03A; // ME=0

    initial begin
        logic [31:0] held;
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs zero under reset
        chk32("R1 flush", {31'd0, entry_flush}, 32'd0);
        chk32("R1 vector", vector, 32'd0);
        chk32("R1 save", save_status, 32'd0);
        chk32("R1 ret", save_pc, 32'd0);
        chk32("R1 msr", msr_next, 32'd0);
        chk32("R1 flags", {29'd0, halted, pend_dec, pend_ext}, 32'd0);
        @(negedge clk); #1; rst_n = 1'b1; cmp_on = 1'b1;

        // R2 R3 R4: system call
        step(4'd12, 13'd0, MSR_A, 32'h0000_1000);
        chk32("R2 syscall flush", {31'd0, entry_flush}, 32'd1);
        chk32("R2 syscall vector", vector, 32'h0000_0C00);
        chk32("R3 syscall msr", msr_next, 32'h0031_1009);
        chk32("R4 syscall ret", save_pc, 32'h0000_1000);
        chk32("R5 syscall save", save_status, MSR_A);
        idle_edge();
        chk32("R2 single pulse", {31'd0, entry_flush}, 32'd0);

        // R2: reset vector with and without relocation
        step(4'd1, 13'd0, 32'h0000_0040, 32'h0000_1100);
        chk32("R2 reset high", vector, 32'hFFF0_0100);
        step(4'd1, 13'd0, 32'h0000_0000, 32'h0000_1100);
        chk32("R2 reset low", vector, 32'h0000_0100);

        // R8: data storage causes
        step(4'd3, 13'h011, MSR_A, 32'h0000_1200);
        chk32("R8 noxlate store", fault_status, 32'h4200_0000);
        chk32("R5 dsi save", save_status, 32'h0000_F03A);
        step(4'd3, 13'h022, MSR_A, 32'h0000_1200);
        chk32("R8 prot brk", fault_status, 32'h0840_0000);
        step(4'd3, 13'h04C, MSR_A, 32'h0000_1200);
        chk32("R8 unsup direct ext", fault_status, 32'h8410_0000);
        step(4'd3, 13'h003, MSR_A, 32'h0000_1200);
        chk32("R8 priority", fault_status, 32'h4000_0000);

        // R9: fault status kept across other entries
        step(4'd12, 13'h07F, MSR_A, 32'h0000_1300);
        chk32("R9 fault held", fault_status, 32'h4000_0000);

        // R6: instruction storage causes
        step(4'd4, 13'h001, MSR_A, 32'h0000_1400);
        chk32("R6 noxlate", save_status, 32'h4000_F03A);
        step(4'd4, 13'h100, MSR_A, 32'h0000_1400);
        chk32("R6 guarded", save_status, 32'h1000_F03A);
        step(4'd4, 13'h008, MSR_A, 32'h0000_1400);
        chk32("R6 direct", save_status, 32'h1000_F03A);
        step(4'd4, 13'h000, MSR_A, 32'h0000_1400);
        chk32("R6 other", save_status, 32'h0800_F03A);

        // R7 R4: program causes and current-address return
        step(4'd7, 13'h600, MSR_A, 32'h0000_2000);
        chk32("R7 fp first", save_status, 32'h0011_F03A);
        chk32("R4 program ret", save_pc, 32'h0000_1FFC);
        step(4'd7, 13'h1000, MSR_A, 32'h0000_2000);
        chk32("R7 trap", save_status, 32'h0003_F03A);
        step(4'd7, 13'h1800, MSR_A, 32'h0000_2000);
        chk32("R7 priv", save_status, 32'h0005_F03A);
        step(4'd6, 13'h000, MSR_A, 32'h0000_3000);
        chk32("R4 align ret", save_pc, 32'h0000_2FFC);
        chk32("R5 align save", save_status, MSR_A);
        step(4'd8, 13'h000, MSR_A, 32'h0000_3100);
        chk32("R4 nofpu ret", save_pc, 32'h0000_30FC);

        // R12: unknown codes ignored
        held = vector;
        step(4'd10, 13'h000, MSR_A, 32'h0000_5000);
        chk32("R12 no flush", {31'd0, entry_flush}, 32'd0);
        chk32("R12 vector held", vector, held);
        step(4'd0, 13'h000, MSR_A, 32'h0000_5000);
        chk32("R12 code zero", {31'd0, entry_flush}, 32'd0);

        // R10: deferral and ordered release
        step(4'd5, 13'h000, MSR_B, 32'h0000_4000);
        chk32("R10 ext pending", {30'd0, pend_dec, pend_ext}, 32'd1);
        chk32("R10 ext not taken", {31'd0, entry_flush}, 32'd0);
        step(4'd9, 13'h000, MSR_B, 32'h0000_4000);
        chk32("R10 both pending", {30'd0, pend_dec, pend_ext}, 32'd3);
        idle_edge();
        chk32("R10 held while masked", {31'd0, entry_flush}, 32'd0);
        @(negedge clk); #1; msr_in = MSR_A; nip_in = 32'h0000_4400;
        idle_edge();
        chk32("R10 ext first", vector, 32'h0000_0500);
        chk32("R10 ext ret", save_pc, 32'h0000_4400);
        chk32("R10 ext cleared", {30'd0, pend_dec, pend_ext}, 32'd2);
        idle_edge();
        chk32("R10 dec next", vector, 32'h0000_0900);
        chk32("R10 all clear", {30'd0, pend_dec, pend_ext}, 32'd0);
        step(4'd5, 13'h000, MSR_B, 32'h0000_4800);
        step(4'd12, 13'h000, MSR_A, 32'h0000_4900);
        chk32("R10 request wins", vector, 32'h0000_0C00);
        chk32("R10 still pending", {31'd0, pend_ext}, 32'd1);
        idle_edge();
        chk32("R10 drained", vector, 32'h0000_0500);

        // R11: machine check enabled then fatal
        held = save_pc;
        step(4'd2, 13'h000, MSR_A, 32'h0000_6000);
        chk32("R11 mchk vector", vector, 32'h0000_0200);
        chk32("R11 me cleared", {31'd0, msr_next[12]}, 32'd0);
        chk32("R4 mchk ret kept", save_pc, held);
        step(4'd2, 13'h000, MSR_C, 32'h0000_6100);
        chk32("R11 halted", {31'd0, halted}, 32'd1);
        chk32("R11 no flush", {31'd0, entry_flush}, 32'd0);
        step(4'd12, 13'h000, MSR_A, 32'h0000_6200);
        chk32("R11 ignores after halt", vector, 32'h0000_0200);
        do_reset();
        chk32("R1 reset clears halt", {31'd0, halted}, 32'd0);
        @(negedge clk); #1; rst_n = 1'b1;

        // Random phase, compared every cycle against the model
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk); #1;
            if (i % 250 == 249) begin
                rst_n = 1'b0;
            end else begin
                rst_n = 1'b1;
                req_valid = ($urandom_range(0, 3) != 0);
                req_kind = 4'($urandom_range(0, 15));
                req_cause = 13'($urandom);
                msr_in = $urandom;
                if ($urandom_range(0, 3) != 0) msr_in[12] = 1'b1;
                nip_in = $urandom & 32'hFFFF_FFFC;
            end
        end
        @(negedge clk); #1; req_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        finish_run();
    end

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=running expected=finished");
            finish_run();
        end
    end

endmodule